// File: doc/BRIEF.md
# Double-Data-Rate Input Capture with Half-Rate Widening

This block receives one or more data pins that carry two bits per strobe period, timed by a strobe forwarded with the data. Each lane is sampled on both strobe edges: one register takes the bit at the rising edge of the effective strobe and another takes the bit at the falling edge. A third register re-times the falling-edge bit onto the next rising edge, so both bits of a pair are presented together. A static control inverts the strobe before capture, which is how memory interfaces that need the opposite polarity are served.

The pair then crosses into a full-rate resynchronization clock through a chain of three stages. Each stage can be bypassed on its own: a resync register, an extra cycle-delay register, and a transfer register clocked on the falling edge of the full-rate clock. A select picks either the word after the resync stage or the word after the whole chain for the full-rate output. A half-rate register, clocked by a clock at half the frequency and aligned with every second full-rate rising edge, packs two consecutive full-rate words into one wide word for the core. A run-time select drives a narrow side output either straight from the data pins or from one bit field of the half-rate word.

Top module: `ddr_rx_lane`

## Requirements
- R1: While `rst_ni` is low, every capture, alignment and half-rate register reads zero, so `fr_word_o` and `hr_word_o` are zero.
- R2: With all alignment stages bypassed, `fr_word_o` just before a full-rate rising edge holds, in bits [2W-1:W], the bit sampled at the latest effective-strobe rising edge, and in bits [W-1:0] the bit sampled at the falling edge before it.
- R3: With `strobe_inv_i` high the effective strobe is the inverted pin, so the capture edges swap and the pair moves by one bit time relative to R2.
- R4: Enabling the resync stage (rising edge of `fr_clk_i`) delays the word seen just before a full-rate rising edge by one full-rate cycle.
- R5: Enabling the cycle-delay stage (rising edge of `fr_clk_i`) adds one further full-rate cycle in the same view.
- R6: The transfer stage samples on the falling edge of `fr_clk_i`. With the resync and delay stages both bypassed it adds one cycle in the R2 view; when either is enabled it re-times the word by half a cycle and adds none.
- R7: `fr_sel_aligned_i` low drives `fr_word_o` from the word after the resync stage (or its bypass); high drives it from the end of the chain.
- R8: At each rising edge of `hr_clk_i`, `hr_word_o[2W-1:0]` takes the chain output from one full-rate cycle earlier and `hr_word_o[4W-1:2W]` the current one, each in the R2 layout.
- R9: `hr_word_o` changes only at rising edges of `hr_clk_i`.
- R10: `hr_direct_i` high drives `direct_o` straight from `dq_i`; low drives it from `hr_word_o[3W-1:2W]`. It may change at run time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fr_clk_i | input | 1 | Full-rate resynchronization clock |
| hr_clk_i | input | 1 | Half-rate resynchronization clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dq_i | input | W | Data pins |
| dqs_i | input | 1 | Forwarded strobe |
| strobe_inv_i | input | 1 | Invert strobe before capture |
| resync_en_i | input | 1 | Enable resync stage |
| cyc_dly_en_i | input | 1 | Enable cycle-delay stage |
| xfer_en_i | input | 1 | Enable falling-edge transfer stage |
| fr_sel_aligned_i | input | 1 | Full-rate output from chain end (1) or resync point (0) |
| hr_direct_i | input | 1 | Side output from pins (1) or half-rate word (0) |
| fr_word_o | output | 2W | Full-rate pair |
| hr_word_o | output | 4W | Half-rate packed word |
| direct_o | output | W | Side output |

## Verification
The checks take for granted that the half-rate clock rises together with every second full-rate rising edge and that the strobe has the same period as the full-rate clock, with its rising edge landing a quarter period before the full-rate rising edge. The stage enables, polarity and output select are treated as static, so the lag properties only fire when the relevant controls held over the cycle they cover. The stimulus keeps all clocks on a fixed phase relation and changes static controls only between scenarios, waiting eight full-rate cycles before checking; only the side-output select is toggled during traffic.

// File: rtl/ddr_rx_pkg.sv
`timescale 1ns/1ps
package ddr_rx_pkg;
  // order of this struct is the order of the chain
  typedef struct packed {
    logic xfer_en;
    logic cyc_dly_en;
    logic resync_en;
  } align_cfg_t;

  localparam int unsigned ALIGN_STAGES = 3;
  localparam int unsigned XFER_STAGE   = ALIGN_STAGES - 1;
endpackage

// File: rtl/ddr_rx_capture.sv
`timescale 1ns/1ps
module ddr_rx_capture #(
  parameter int unsigned W = 1
) (
  input  logic           dqs_i,
  input  logic           inv_i,
  input  logic           rst_ni,
  input  logic [W-1:0]   dq_i,
  output logic [2*W-1:0] pair_o
);
  logic stb;
  assign stb = dqs_i ^ inv_i;

  logic [W-1:0] rise_q, fall_q, fall_rt_q;

  for (genvar i = 0; i < W; i++) begin : g_lane
    always_ff @(posedge stb or negedge rst_ni) begin
      if (!rst_ni) rise_q[i] <= 1'b0;
      else         rise_q[i] <= dq_i[i];
    end

    always_ff @(negedge stb or negedge rst_ni) begin
      if (!rst_ni) fall_q[i] <= 1'b0;
      else         fall_q[i] <= dq_i[i];
    end

    // re-time falling-edge bit onto the rising edge
    always_ff @(posedge stb or negedge rst_ni) begin
      if (!rst_ni) fall_rt_q[i] <= 1'b0;
      else         fall_rt_q[i] <= fall_q[i];
    end
  end

  assign pair_o = {rise_q, fall_rt_q};
endmodule

// File: rtl/ddr_rx_stage.sv
`timescale 1ns/1ps
module ddr_rx_stage #(
  parameter int unsigned W   = 2,
  parameter bit          NEG = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  if (NEG) begin : g_neg
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= d_i;
    end
  end else begin : g_pos
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= d_i;
    end
  end

  assign q_o = en_i ? q : d_i;
endmodule

// File: rtl/ddr_rx_align.sv
`timescale 1ns/1ps
module ddr_rx_align
  import ddr_rx_pkg::*;
#(
  parameter int unsigned W = 1
) (
  input  logic           fr_clk_i,
  input  logic           rst_ni,
  input  align_cfg_t     cfg_i,
  input  logic [2*W-1:0] pair_i,
  output logic [2*W-1:0] pre_o,
  output logic [2*W-1:0] aligned_o
);
  localparam int unsigned PW = 2 * W;

  logic [ALIGN_STAGES-1:0] en;
  logic [PW-1:0]           chain [ALIGN_STAGES+1];

  assign en       = cfg_i;
  assign chain[0] = pair_i;

  for (genvar s = 0; s < ALIGN_STAGES; s++) begin : g_stage
    ddr_rx_stage #(
      .W   (PW),
      .NEG (s == XFER_STAGE)
    ) u_stage (
      .clk_i  (fr_clk_i),
      .rst_ni (rst_ni),
      .en_i   (en[s]),
      .d_i    (chain[s]),
      .q_o    (chain[s+1])
    );
  end

  assign pre_o     = chain[1];
  assign aligned_o = chain[ALIGN_STAGES];
endmodule

// File: rtl/ddr_rx_halfrate.sv
`timescale 1ns/1ps
module ddr_rx_halfrate #(
  parameter int unsigned W = 1
) (
  input  logic           fr_clk_i,
  input  logic           hr_clk_i,
  input  logic           rst_ni,
  input  logic [2*W-1:0] word_i,
  output logic [4*W-1:0] hr_o
);
  logic [2*W-1:0] prev_q;
  logic [4*W-1:0] hr_q;

  always_ff @(posedge fr_clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= word_i;
  end

  // earlier word low, later word high
  always_ff @(posedge hr_clk_i or negedge rst_ni) begin
    if (!rst_ni) hr_q <= '0;
    else         hr_q <= {word_i, prev_q};
  end

  assign hr_o = hr_q;
endmodule

// File: rtl/ddr_rx_lane.sv
`timescale 1ns/1ps
module ddr_rx_lane
  import ddr_rx_pkg::*;
#(
  parameter int unsigned W = 1
) (
  input  logic           fr_clk_i,
  input  logic           hr_clk_i,
  input  logic           rst_ni,
  input  logic [W-1:0]   dq_i,
  input  logic           dqs_i,
  input  logic           strobe_inv_i,
  input  logic           resync_en_i,
  input  logic           cyc_dly_en_i,
  input  logic           xfer_en_i,
  input  logic           fr_sel_aligned_i,
  input  logic           hr_direct_i,
  output logic [2*W-1:0] fr_word_o,
  output logic [4*W-1:0] hr_word_o,
  output logic [W-1:0]   direct_o
);
  logic [2*W-1:0] cap_pair;
  logic [2*W-1:0] pre_word;
  logic [2*W-1:0] aligned_word;
  align_cfg_t     cfg;

  assign cfg = '{xfer_en: xfer_en_i, cyc_dly_en: cyc_dly_en_i, resync_en: resync_en_i};

  ddr_rx_capture #(.W(W)) u_cap (
    .dqs_i  (dqs_i),
    .inv_i  (strobe_inv_i),
    .rst_ni (rst_ni),
    .dq_i   (dq_i),
    .pair_o (cap_pair)
  );

  ddr_rx_align #(.W(W)) u_align (
    .fr_clk_i  (fr_clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     (cfg),
    .pair_i    (cap_pair),
    .pre_o     (pre_word),
    .aligned_o (aligned_word)
  );

  ddr_rx_halfrate #(.W(W)) u_hr (
    .fr_clk_i (fr_clk_i),
    .hr_clk_i (hr_clk_i),
    .rst_ni   (rst_ni),
    .word_i   (aligned_word),
    .hr_o     (hr_word_o)
  );

  assign fr_word_o = fr_sel_aligned_i ? aligned_word : pre_word;
  assign direct_o  = hr_direct_i ? dq_i : hr_word_o[3*W-1:2*W];
endmodule

// File: rtl/ddr_rx_lane_chk.sv
`timescale 1ns/1ps
module ddr_rx_lane_chk #(
  parameter int unsigned W = 1
) (
  input logic           fr_clk_i,
  input logic           hr_clk_i,
  input logic           rst_ni,
  input logic [W-1:0]   dq_i,
  input logic           dqs_i,
  input logic           strobe_inv_i,
  input logic           resync_en_i,
  input logic           cyc_dly_en_i,
  input logic           xfer_en_i,
  input logic           fr_sel_aligned_i,
  input logic           hr_direct_i,
  input logic [2*W-1:0] fr_word_o,
  input logic [4*W-1:0] hr_word_o,
  input logic [W-1:0]   direct_o,
  input logic [2*W-1:0] cap_pair,
  input logic [2*W-1:0] pre_word,
  input logic [2*W-1:0] aligned_word
);
  logic eff_stb;
  assign eff_stb = dqs_i ^ strobe_inv_i;

  // R1
  always @(posedge fr_clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_clear: assert (fr_word_o == '0 && hr_word_o == '0)
        else $error("R1 outputs not clear in reset");
    end
  end

  a_r2_rise_capture: assert property (@(posedge eff_stb) disable iff (!rst_ni)
    1'b1 |=> cap_pair[2*W-1:W] == $past(dq_i));

  a_r4_resync_lag: assert property (@(posedge fr_clk_i) disable iff (!rst_ni)
    (resync_en_i && !fr_sel_aligned_i) |=>
      (!resync_en_i || fr_sel_aligned_i || fr_word_o == $past(cap_pair)));

  a_r5_delay_lag: assert property (@(posedge fr_clk_i) disable iff (!rst_ni)
    (cyc_dly_en_i && !xfer_en_i) |=>
      (!cyc_dly_en_i || xfer_en_i || aligned_word == $past(pre_word)));

  a_r9_hr_hold: assert property (@(negedge fr_clk_i) disable iff (!rst_ni)
    hr_clk_i |=> $stable(hr_word_o));

  a_r10_direct_hold: assert property (@(negedge fr_clk_i) disable iff (!rst_ni)
    (hr_clk_i && !hr_direct_i) |=> (hr_direct_i || $stable(direct_o)));
endmodule

bind ddr_rx_lane ddr_rx_lane_chk #(.W(W)) u_chk (
  .fr_clk_i         (fr_clk_i),
  .hr_clk_i         (hr_clk_i),
  .rst_ni           (rst_ni),
  .dq_i             (dq_i),
  .dqs_i            (dqs_i),
  .strobe_inv_i     (strobe_inv_i),
  .resync_en_i      (resync_en_i),
  .cyc_dly_en_i     (cyc_dly_en_i),
  .xfer_en_i        (xfer_en_i),
  .fr_sel_aligned_i (fr_sel_aligned_i),
  .hr_direct_i      (hr_direct_i),
  .fr_word_o        (fr_word_o),
  .hr_word_o        (hr_word_o),
  .direct_o         (direct_o),
  .cap_pair         (cap_pair),
  .pre_word         (pre_word),
  .aligned_word     (aligned_word)
);

// File: tb/ddr_rx_lane_test.sv
`timescale 1ns/100ps
module ddr_rx_lane_test;
  localparam int W = 1;

  logic fr_clk = 1'b0, hr_clk = 1'b0, dqs = 1'b0, rst_n = 1'b0;
  logic [W-1:0] dq = '0;
  logic inv = 1'b0, res = 1'b0, dly = 1'b0, xfer = 1'b0, sel = 1'b0, hdir = 1'b0;
  logic [2*W-1:0] fr_word;
  logic [4*W-1:0] hr_word;
  logic [W-1:0]   direct;

  int n_chk = 0, n_fail = 0;
  int fr_cnt = 0, n_idx = 0;
  int pat_mode = 0;
  int pat_seed = 0;
  bit done = 1'b0;

  ddr_rx_lane #(.W(W)) uut (
    .fr_clk_i(fr_clk), .hr_clk_i(hr_clk), .rst_ni(rst_n), .dq_i(dq), .dqs_i(dqs),
    .strobe_inv_i(inv), .resync_en_i(res), .cyc_dly_en_i(dly), .xfer_en_i(xfer),
    .fr_sel_aligned_i(sel), .hr_direct_i(hdir),
    .fr_word_o(fr_word), .hr_word_o(hr_word), .direct_o(direct)
  );

  // 100 MHz full-rate; half-rate rises with every second full-rate rise;
  // strobe rises a quarter period before each full-rate rise
  initial forever #5 fr_clk = ~fr_clk;
  initial begin #5 hr_clk = 1'b1; forever #10 hr_clk = ~hr_clk; end
  initial begin #2.5 dqs = 1'b1; forever #5 dqs = ~dqs; end
  initial forever begin @(posedge fr_clk); fr_cnt++; end

  function automatic logic bit_of(int n);
    logic [31:0] x;
    if (n < 0) return 1'b0;
    case (pat_mode)
      1:       return n[0];
      2:       return 1'b1;
      default: begin
        x = (32'(n) + 32'(pat_seed)) * 32'h9E37_79B1;
        return x[20] ^ x[13];
      end
    endcase
  endfunction

  // bit n is on the pin during [5n, 5n+5)
  initial forever begin dq = bit_of(n_idx); #5; n_idx++; end

  // word present just before rising edge m with all stages bypassed (R2)
  function automatic logic [1:0] w_at(int j);
    return {bit_of(2*j), bit_of(2*j-1)};
  endfunction

  // R4/R5/R6 latency in the just-before-edge view
  function automatic int lat();
    int k;
    k = int'(res) + int'(dly);
    return (k == 0) ? int'(xfer) : k;
  endfunction

  function automatic logic [1:0] a_at(int j);
    return w_at(j - lat());
  endfunction

  function automatic logic [3:0] exp_hr(int m);
    int j;
    j = m[0] ? m - 1 : m - 2;
    return {a_at(j), a_at(j - 1)};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // samples at 10m+4: one ns before the rising edge of cycle m
  task automatic step();
    @(posedge fr_clk);
    #9;
  endtask

  task automatic set_cfg(logic i, logic r, logic d, logic x, logic s);
    inv = i; res = r; dly = d; xfer = x; sel = s;
    repeat (8) step();
  endtask

  task automatic test_reset();
    hdir = 1'b0;
    repeat (3) step();
    check("R1 fr_word", 8'(fr_word), 8'h0);
    check("R1 hr_word", 8'(hr_word), 8'h0);
    check("R1 direct",  8'(direct),  8'h0);
    rst_n = 1'b1;
    repeat (4) step();
  endtask

  task automatic test_latency(logic r, logic d, logic x, string tag);
    int m;
    set_cfg(1'b0, r, d, x, 1'b1);
    for (int i = 0; i < 4; i++) begin
      step();
      m = fr_cnt;
      check(tag, 8'(fr_word), 8'(a_at(m)));
      check("R8 packing", 8'(hr_word), 8'(exp_hr(m)));
    end
  endtask

  task automatic test_presel();
    int m;
    set_cfg(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      step(); m = fr_cnt;
      check("R7 resync point", 8'(fr_word), 8'(w_at(m - 1)));
    end
    set_cfg(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      step(); m = fr_cnt;
      check("R7 R2 capture point", 8'(fr_word), 8'(w_at(m)));
    end
  endtask

  task automatic test_inv();
    int m;
    set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      step(); m = fr_cnt;
      check("R3 inverted strobe", 8'(fr_word), 8'({bit_of(2*m-1), bit_of(2*m-2)}));
    end
    set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic test_patterns();
    int m;
    for (int p = 1; p <= 2; p++) begin
      pat_mode = p;
      set_cfg(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
      for (int i = 0; i < 3; i++) begin
        step(); m = fr_cnt;
        check("R5 pattern", 8'(fr_word), 8'(a_at(m)));
        check("R8 pattern", 8'(hr_word), 8'(exp_hr(m)));
      end
    end
    pat_mode = 0;
    set_cfg(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic test_hold();
    logic [3:0] first;
    while (fr_cnt[0] == 1'b0) step();
    for (int i = 0; i < 3; i++) begin
      first = hr_word;
      step();
      check("R9 hold between half-rate edges", 8'(hr_word), 8'(first));
      step();
    end
  endtask

  task automatic test_direct();
    int m;
    for (int i = 0; i < 6; i++) begin
      hdir = i[0];
      step(); m = fr_cnt;
      if (hdir) check("R10 pin path", 8'(direct), 8'(bit_of(2*m)));
      else      check("R10 half-rate path", 8'(direct), 8'(exp_hr(m)[2]));
    end
    hdir = 1'b0;
  endtask

  initial begin
    test_reset();
    for (int c = 0; c < 8; c++) begin
      pat_seed = c * 7 + 3;
      test_latency(c[0], c[1], c[2],
                   c[2] ? "R6 transfer" : (c[1] ? "R5 delay" : (c[0] ? "R4 resync" : "R2 bypassed")));
    end
    test_presel();
    test_inv();
    test_patterns();
    test_hold();
    test_direct();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule